// File: doc/BRIEF.md
# IOMMU Control Register File

This block is the software-visible register bank of an I/O address-translation unit. A processor reaches it over a simple word-wide register bus with a valid strobe, a write flag, a byte address, write data, and registered read data. The bank holds the control word, the page-table base, the fault status and fault address pair, the arbiter and arbitration enables, four per-slot configuration words and a mask identifier. Every other word in the 16KB space, including the two flush words, is plain 32-bit storage.

Each named register has its own write rule. Some bits are kept under a mask, some bits always read as one, and the mask identifier only accumulates bits. A write to the control word also updates the start address of the DVMA window, which is taken from a three-bit range code. The window always ends at the top of the 32-bit space.

A separate translation engine reads the page-table base, the window start and the enable. When it detects a fault, it loads the fault registers through a side port. That load raises a level interrupt. Any bus access to either fault register clears the interrupt again.

Top module: `iommu_regfile`

## Requirements
- R1: A read presented in cycle N returns its data with `rd_valid` high in cycle N+1; `rd_valid` is low in every other cycle.
- R2: The control word at offset 0x0000 keeps only the written bits under 0x0000001D. It reads back with the `VERSION` parameter in bits [31:24]; after reset it reads as that byte alone. `xlate_en` follows its bit 0.
- R3: A control write with range code c in bits [4:2] sets `win_start` to 0xFFFFFFFF shifted left by 24+c, so code 0 gives 0xFF000000 and code 7 gives 0x80000000. `win_start` is 0 after reset and changes only on control writes.
- R4: The page-table base at offset 0x0004 keeps only bits under 0x07FFFC00, resets to 0, and drives `pt_base`.
- R5: The fault status word at offset 0x1000 keeps written bits under 0xFF0FFFFF. Bit 23 is set after every write and at reset, so the reset value is 0x00800000.
- R6: The arbiter enable word at offset 0x1008 keeps bits under 0x801F000F. Bit 0 always reads as 1, and the reset value is 0x00000003.
- R7: The arbitration enable word at offset 0x2000 keeps bits under 0x001F0000. Bit 3 always reads as 1, and the reset value is 0x00000008.
- R8: A write to the mask identifier at offset 0x3018 ORs the written bits under 0x00FFFFFF into the stored value and never clears a bit. The reset value is 0x23000000.
- R9: The four slot configuration words at offsets 0x1010, 0x1014, 0x1018 and 0x101C each keep only bits under 0x00010003 and reset to 0. Each word is independent of the others.
- R10: The flush words at 0x0014 and 0x0018, and every offset not named above, store and return the full 32-bit value written.
- R11: A `fault_set` pulse loads the fault status word with `fault_status` under the R5 mask with bit 23 set. It loads the fault address word at 0x1004 with `fault_addr`, and raises `fault_irq` in the next cycle. A bus write to a fault register in the same cycle is overridden by the load.
- R12: Any bus read or write of the fault status or fault address word drops `fault_irq` in the next cycle, unless `fault_set` is high in the same cycle, in which case the interrupt stays raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the word |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| fault_set | input | 1 | Fault load strobe from the translation engine |
| fault_status | input | 32 | Fault status value to load |
| fault_addr | input | 32 | Faulting address to load |
| fault_irq | output | 1 | Level fault interrupt |
| pt_base | output | 32 | Current page-table base |
| win_start | output | 32 | Start address of the DVMA window |
| xlate_en | output | 1 | Translation enable (control bit 0) |

## Verification
Each masked register is written with all ones and then all zeros. This pattern separates a missing mask from a missing forced bit. The mask identifier is written with disjoint bit groups and then with zero, which shows whether the OR-in rule is kept or replaced by a plain store. All eight range codes are stepped through so that any shift or decode error shows in `win_start`. Interrupt tests raise the fault and then clear it by a read of the address word and by a write of the status word, and a fault load coincides with a status read, which checks the priority between setting and clearing.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;

    localparam int DATA_W = 32;

    // Word indices (byte offset >> 2) of the named registers
    localparam int IDX_CTRL   = 'h000;
    localparam int IDX_BASE   = 'h001;
    localparam int IDX_AFSR   = 'h400;
    localparam int IDX_AFAR   = 'h401;
    localparam int IDX_AER    = 'h402;
    localparam int IDX_SLOT0  = 'h404;
    localparam int NUM_SLOTS  = 4;
    localparam int IDX_ARBEN  = 'h800;
    localparam int IDX_MASKID = 'hC06;

    // Write masks and forced bits
    localparam logic [31:0] CTRL_KEEP   = 32'h0000_001D;
    localparam logic [31:0] BASE_KEEP   = 32'h07FF_FC00;
    localparam logic [31:0] AFSR_KEEP   = 32'hFF0F_FFFF;
    localparam logic [31:0] AFSR_FORCE  = 32'h0080_0000;
    localparam logic [31:0] AER_KEEP    = 32'h801F_000F;
    localparam logic [31:0] AER_FORCE   = 32'h0000_0001;
    localparam logic [31:0] AER_RESET   = 32'h0000_0003;
    localparam logic [31:0] SLOT_KEEP   = 32'h0001_0003;
    localparam logic [31:0] ARBEN_KEEP  = 32'h001F_0000;
    localparam logic [31:0] ARBEN_FORCE = 32'h0000_0008;
    localparam logic [31:0] MASKID_KEEP = 32'h00FF_FFFF;
    localparam logic [31:0] MASKID_RST  = 32'h2300_0000;

    typedef enum logic [3:0] {
        K_CTRL, K_BASE, K_AFSR, K_AFAR, K_AER,
        K_SLOT, K_ARBEN, K_MASKID, K_PLAIN
    } reg_kind_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        reg_kind_e   kind;
        logic [31:0] data;
    } bus_op_t;

    function automatic reg_kind_e classify(input logic [31:0] idx);
        if (idx == 32'(IDX_CTRL))        return K_CTRL;
        else if (idx == 32'(IDX_BASE))   return K_BASE;
        else if (idx == 32'(IDX_AFSR))   return K_AFSR;
        else if (idx == 32'(IDX_AFAR))   return K_AFAR;
        else if (idx == 32'(IDX_AER))    return K_AER;
        else if (idx >= 32'(IDX_SLOT0) && idx < 32'(IDX_SLOT0 + NUM_SLOTS))
                                         return K_SLOT;
        else if (idx == 32'(IDX_ARBEN))  return K_ARBEN;
        else if (idx == 32'(IDX_MASKID)) return K_MASKID;
        else                             return K_PLAIN;
    endfunction

    // Window ends at 0xFFFFFFFF; size is 16MB << code
    function automatic logic [31:0] window_base(input logic [2:0] code);
        return 32'hFFFF_FFFF << (5'd24 + {2'b00, code});
    endfunction

endpackage

// File: rtl/iommu_win_decode.sv
module iommu_win_decode
    import iommu_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [2:0]  code,
    output logic [31:0] start
);
    always_ff @(posedge clk) begin
        if (rst)       start <= '0;
        else if (load) start <= window_base(code);
    end
endmodule

// File: rtl/iommu_fault_irq.sv
module iommu_fault_irq (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic clear,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)        irq <= 1'b0;
        else if (raise) irq <= 1'b1;
        else if (clear) irq <= 1'b0;
    end
endmodule

// File: rtl/iommu_plain_store.sv
module iommu_plain_store #(
    parameter int IDX_W = 12,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/iommu_regfile.sv
module iommu_regfile
    import iommu_regs_pkg::*;
#(
    parameter int         ADDR_W  = 14,
    parameter logic [7:0] VERSION = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              fault_set,
    input  logic [31:0]       fault_status,
    input  logic [31:0]       fault_addr,
    output logic              fault_irq,
    output logic [31:0]       pt_base,
    output logic [31:0]       win_start,
    output logic              xlate_en
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    bus_op_t          op;

    assign idx     = req_addr[ADDR_W-1:2];
    assign op.rd   = req_valid & ~req_write;
    assign op.wr   = req_valid & req_write;
    assign op.kind = classify(32'(idx));
    assign op.data = req_wdata;

    logic [31:0] ctrl_q, base_q, afsr_q, afar_q, aer_q, arben_q, maskid_q;
    logic [31:0] slot_q [NUM_SLOTS];

    // Named registers with their own write rules
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            base_q   <= '0;
            afsr_q   <= AFSR_FORCE;
            afar_q   <= '0;
            aer_q    <= AER_RESET;
            arben_q  <= ARBEN_FORCE;
            maskid_q <= MASKID_RST;
        end else begin
            if (op.wr) begin
                case (op.kind)
                    K_CTRL:   ctrl_q   <= op.data & CTRL_KEEP;
                    K_BASE:   base_q   <= op.data & BASE_KEEP;
                    K_AFSR:   afsr_q   <= (op.data & AFSR_KEEP) | AFSR_FORCE;
                    K_AFAR:   afar_q   <= op.data;
                    K_AER:    aer_q    <= (op.data & AER_KEEP) | AER_FORCE;
                    K_ARBEN:  arben_q  <= (op.data & ARBEN_KEEP) | ARBEN_FORCE;
                    K_MASKID: maskid_q <= maskid_q | (op.data & MASKID_KEEP);
                    default: ;
                endcase
            end
            if (fault_set) begin
                afsr_q <= (fault_status & AFSR_KEEP) | AFSR_FORCE;
                afar_q <= fault_addr;
            end
        end
    end

    // Per-slot configuration words
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (op.wr && op.kind == K_SLOT && idx[1:0] == 2'(g))
                slot_q[g] <= op.data & SLOT_KEEP;
        end
    end

    // Window start decode
    iommu_win_decode u_win (
        .clk   (clk),
        .rst   (rst),
        .load  (op.wr && op.kind == K_CTRL),
        .code  (op.data[4:2]),
        .start (win_start)
    );

    // Fault interrupt
    logic fault_touch;
    assign fault_touch = req_valid && (op.kind == K_AFSR || op.kind == K_AFAR);

    iommu_fault_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .raise (fault_set),
        .clear (fault_touch),
        .irq   (fault_irq)
    );

    // Plain storage for every other word
    logic [31:0] plain_rdata;

    iommu_plain_store #(.IDX_W(IDX_W), .WIDTH(DATA_W)) u_store (
        .clk   (clk),
        .we    (op.wr && op.kind == K_PLAIN),
        .re    (op.rd && op.kind == K_PLAIN),
        .addr  (idx),
        .wdata (op.data),
        .rdata (plain_rdata)
    );

    // Read path
    logic [31:0] named_val;
    always_comb begin
        case (op.kind)
            K_CTRL:   named_val = ctrl_q | {VERSION, 24'h0};
            K_BASE:   named_val = base_q;
            K_AFSR:   named_val = afsr_q;
            K_AFAR:   named_val = afar_q;
            K_AER:    named_val = aer_q;
            K_SLOT:   named_val = slot_q[idx[1:0]];
            K_ARBEN:  named_val = arben_q;
            K_MASKID: named_val = maskid_q;
            default:  named_val = '0;
        endcase
    end

    logic        rd_valid_q, named_sel_q;
    logic [31:0] named_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q  <= 1'b0;
            named_sel_q <= 1'b0;
            named_q     <= '0;
        end else begin
            rd_valid_q <= op.rd;
            if (op.rd) begin
                named_sel_q <= (op.kind != K_PLAIN);
                named_q     <= named_val;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = named_sel_q ? named_q : plain_rdata;
    assign pt_base  = base_q;
    assign xlate_en = ctrl_q[0];

endmodule

// File: rtl/iommu_regfile_chk.sv
module iommu_regfile_chk
    import iommu_regs_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              fault_set,
    input logic              fault_irq,
    input logic [31:0]       win_start
);
    logic [31:0] widx;
    logic        ctrl_wr, fault_acc, is_rd;

    assign widx      = 32'(req_addr[ADDR_W-1:2]);
    assign ctrl_wr   = req_valid && req_write && widx == 32'(IDX_CTRL);
    assign fault_acc = req_valid && (widx == 32'(IDX_AFSR) || widx == 32'(IDX_AFAR));
    assign is_rd     = req_valid && !req_write;

    // R1
    a_r1_read_latency: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> rd_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !is_rd |=> !rd_valid);

    // R3
    a_r3_window_value: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> win_start == ~((32'd1 << (24 + 32'($past(req_wdata[4:2])))) - 32'd1));
    a_r3_window_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(win_start));

    // R11
    a_r11_fault_raise: assert property (@(posedge clk) disable iff (rst)
        fault_set |=> fault_irq);

    // R12
    a_r12_access_clears: assert property (@(posedge clk) disable iff (rst)
        (fault_acc && !fault_set) |=> !fault_irq);

    // R5
    a_r5_status_bit23: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(widx) == 32'(IDX_AFSR)) |-> rd_data[23]);

    // R6
    a_r6_aer_bit0: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(widx) == 32'(IDX_AER)) |-> rd_data[0]);

    // R7
    a_r7_arben_bit3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(widx) == 32'(IDX_ARBEN)) |-> rd_data[3]);

endmodule

bind iommu_regfile iommu_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .fault_set (fault_set),
    .fault_irq (fault_irq),
    .win_start (win_start)
);

// File: tb/iommu_regfile_tb.sv
`timescale 1ns/1ps
module iommu_regfile_tb;
    localparam logic [7:0] VER = 8'hA5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [13:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        fault_set = 1'b0;
    logic [31:0] fault_status = '0, fault_addr = '0;
    logic        fault_irq;
    logic [31:0] pt_base, win_start;
    logic        xlate_en;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    iommu_regfile #(.ADDR_W(14), .VERSION(VER)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .fault_set(fault_set), .fault_status(fault_status),
        .fault_addr(fault_addr), .fault_irq(fault_irq), .pt_base(pt_base),
        .win_start(win_start), .xlate_en(xlate_en)
    );

    // Behavioural reference model
    logic [31:0] m [int];
    logic [31:0] m_win;
    bit          m_irq, m_rv, m_known;
    logic [31:0] m_rd;
    string       m_tag;

    function automatic string tag_of(int w);
        case (w)
            0:            return "R2";
            1:            return "R4";
            'h400, 'h401: return "R11";
            'h402:        return "R6";
            'h404, 'h405, 'h406, 'h407: return "R9";
            'h800:        return "R7";
            'hC06:        return "R8";
            default:      return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m.delete();
        m[0] = 0; m[1] = 0; m['h400] = 32'h0080_0000; m['h401] = 0;
        m['h402] = 3; m['h800] = 8; m['hC06] = 32'h2300_0000;
        for (int s = 0; s < 4; s++) m['h404 + s] = 0;
        m_win = 0; m_irq = 0; m_rv = 0; m_known = 0;
    endtask

    task automatic model_write(int w, logic [31:0] d);
        case (w)
            0: begin m[0] = d & 32'h1D; m_win = 32'hFFFF_FFFF << (24 + int'(d[4:2])); end
            1: m[1] = d & 32'h07FF_FC00;
            'h400: m[w] = (d & 32'hFF0F_FFFF) | 32'h0080_0000;
            'h402: m[w] = (d & 32'h801F_000F) | 32'h1;
            'h404, 'h405, 'h406, 'h407: m[w] = d & 32'h0001_0003;
            'h800: m[w] = (d & 32'h001F_0000) | 32'h8;
            'hC06: m[w] = m[w] | (d & 32'h00FF_FFFF);
            default: m[w] = d;
        endcase
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) model_reset();
        else begin
            int w;
            w = int'(req_addr[13:2]);
            m_rv = req_valid && !req_write;
            if (m_rv) begin
                m_known = m.exists(w);
                m_rd    = m_known ? m[w] : 32'h0;
                if (w == 0) m_rd = m_rd | {VER, 24'h0};
                m_tag = tag_of(w);
            end
            if (req_valid && req_write) model_write(w, req_wdata);
            if (fault_set) begin
                m['h400] = (fault_status & 32'hFF0F_FFFF) | 32'h0080_0000;
                m['h401] = fault_addr;
                m_irq = 1;
            end else if (req_valid && (w == 'h400 || w == 'h401)) m_irq = 0;
        end
        @(negedge clk);
        chk("R1", "rd_valid", 32'(rd_valid), 32'(m_rv));
        if (m_rv && m_known) chk(m_tag, "rd_data", rd_data, m_rd);
        chk("R12", "fault_irq", 32'(fault_irq), 32'(m_irq));
        chk("R3", "win_start", win_start, m_win);
        chk("R4", "pt_base", pt_base, m[1]);
        chk("R2", "xlate_en", 32'(xlate_en), 32'(m[0][0]));
    endtask

    task automatic bus_wr(logic [13:0] a, logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        tick();
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(logic [13:0] a);
        req_valid = 1; req_write = 0; req_addr = a;
        tick();
        req_valid = 0;
    endtask

    task automatic fault(logic [31:0] st, logic [31:0] ad);
        fault_set = 1; fault_status = st; fault_addr = ad;
        tick();
        fault_set = 0;
    endtask

    initial begin
        rst = 1;
        tick(); tick();
        rst = 0;
        tick();

        // Reset values (R2, R5, R6, R7, R8, R9)
        bus_rd(14'h0000); bus_rd(14'h0004); bus_rd(14'h1000); bus_rd(14'h1004);
        bus_rd(14'h1008); bus_rd(14'h2000); bus_rd(14'h3018);
        for (int s = 0; s < 4; s++) bus_rd(14'(14'h1010 + 4 * s));
        tick();

        // R2/R3: all range codes, enable on and off
        for (int c = 0; c < 8; c++) begin
            bus_wr(14'h0000, 32'hFFFF_FFE0 | (32'(c) << 2) | 32'(c & 1));
            bus_rd(14'h0000);
        end
        bus_wr(14'h0000, 32'h0000_0000);
        bus_rd(14'h0000);
        tick();

        // R4, R5, R6, R7: all ones then all zeros
        for (int p = 0; p < 2; p++) begin
            logic [31:0] d;
            d = (p == 0) ? 32'hFFFF_FFFF : 32'h0;
            bus_wr(14'h0004, d); bus_rd(14'h0004);
            bus_wr(14'h1000, d); bus_rd(14'h1000);
            bus_wr(14'h1008, d); bus_rd(14'h1008);
            bus_wr(14'h2000, d); bus_rd(14'h2000);
        end

        // R8: sticky OR-in
        bus_wr(14'h3018, 32'hFF00_0F0F); bus_rd(14'h3018);
        bus_wr(14'h3018, 32'h00F0_0000); bus_rd(14'h3018);
        bus_wr(14'h3018, 32'h0000_0000); bus_rd(14'h3018);

        // R9: independent slots
        for (int s = 0; s < 4; s++) bus_wr(14'(14'h1010 + 4 * s), 32'hFFFF_FFFF ^ 32'(s));
        for (int s = 0; s < 4; s++) bus_rd(14'(14'h1010 + 4 * s));

        // R10: flush words and unnamed offsets
        bus_wr(14'h0014, 32'hDEAD_BEEF); bus_wr(14'h0018, 32'h1234_5678);
        bus_wr(14'h2004, 32'hA5A5_5A5A); bus_wr(14'h3FFC, 32'h0F0F_F0F0);
        bus_rd(14'h0014); bus_rd(14'h0018); bus_rd(14'h2004); bus_rd(14'h3FFC);

        // R11/R12: raise, clear by address read
        fault(32'hFFFF_FFFF, 32'hFC00_1000);
        tick();
        bus_rd(14'h1000);
        fault(32'h4000_0000, 32'hFF12_3000);
        bus_rd(14'h1004);
        tick();
        // clear by status write
        fault(32'h0000_0000, 32'h8000_0000);
        bus_wr(14'h1000, 32'h0000_0000);
        bus_rd(14'h1000);
        // set and read in the same cycle: set wins, read sees old value
        fault_set = 1; fault_status = 32'h2000_0000; fault_addr = 32'hF000_0004;
        req_valid = 1; req_write = 0; req_addr = 14'h1000;
        tick();
        fault_set = 0; req_valid = 0;
        tick();
        // fault load overrides a same-cycle bus write
        fault_set = 1; fault_status = 32'h1000_0000; fault_addr = 32'hE000_0000;
        req_valid = 1; req_write = 1; req_addr = 14'h1004; req_wdata = 32'h1111_1111;
        tick();
        fault_set = 0; req_valid = 0; req_write = 0;
        bus_rd(14'h1004); bus_rd(14'h1000);
        tick(); tick();

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule